// File: doc/BRIEF.md
# Conversion Clock Gate Controller

This block meters the conversion clock of a 14-bit successive-approximation converter. The clock source is either a free-running internal divider or an external clock pin. An accepted start opens a gate that lets exactly sixteen complete source cycles through to the conversion engine. After the sixteenth cycle, an end-of-conversion flag closes the gate, however long the source keeps running.

Everything runs on one system clock. The external clock passes through a synchronizer. The engine clock and the clock-out pin are registered levels that follow the selected source one system cycle late, so the block creates no gated clock nets. The clock-out pin repeats the engine cycles only while both chip-select and read are low, and it is held low otherwise. A high chip-select blocks new conversions. Every pin is a plain control or status signal: no data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `cnvclk_gate_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no start, busy_o, eoc_o, eng_clk_o and clk_out_o are all low.
- R2: A start is accepted when start_i is high, cs_n_i is low and busy_o is low. One clock edge later, busy_o is high and eoc_o is low.
- R3: Each accepted conversion produces exactly CYCLES (default 16) high pulses on eng_clk_o, even if the source keeps running. Each pulse is a complete high phase that begins on a source rising edge. eng_clk_o never pulses while busy_o is low.
- R4: The clock edge that ends the last eng_clk_o pulse also lowers busy_o and raises eoc_o. eoc_o then stays high until the next accepted start.
- R5: ext_sel_i is sampled when a start is accepted: 1 selects the external clock and 0 selects the internal divider, whose period is 2*INT_HALF system cycles. Changing ext_sel_i during a conversion has no effect on that conversion.
- R6: clk_out_o equals eng_clk_o in every cycle in which cs_n_i and rd_n_i were both low in the previous cycle. In every other cycle, clk_out_o is low.
- R7: A start that arrives while cs_n_i is high is ignored: busy_o stays low and no engine pulses appear.
- R8: A start that arrives while busy_o is high is ignored. The running conversion still ends after exactly CYCLES pulses, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-conversion request |
| ext_sel_i | input | 1 | Clock source select: 1 external, 0 internal |
| ext_clk_i | input | 1 | External conversion clock, asynchronous |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read enable for clock-out |
| eng_clk_o | output | 1 | Gated conversion clock to the engine |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End of conversion, blocks further cycles |
| clk_out_o | output | 1 | Mirror of the engine clock for the pin |

## Verification
The external clock keeps running long after each conversion. A design without a hard cycle cutoff would go on pulsing the engine, and the scoreboard would see pulses while the block is idle. A second start is fired in the middle of a conversion. A design that restarts its counter would deliver more than sixteen pulses. The select input is flipped during an external-clock conversion. A design that follows the live select would finish in internal-divider time, and the conversion-length bound catches it. Conversions with read held high, and starts with chip-select held high, expose a clock-out pin that ignores the selects and a start that is not blocked.

// File: rtl/cnvclk_pkg.sv
package cnvclk_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;

  function automatic int cnt_width(input int cycles);
    return $clog2(cycles) + 1;
  endfunction
endpackage

// File: rtl/cnvclk_src.sv
module cnvclk_src
  import cnvclk_pkg::*;
#(
  parameter int INT_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic ext_clk_i,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int DIV_W = $clog2(INT_HALF) + 1;

  logic [DIV_W-1:0]       div_q;
  logic                   int_lvl, int_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_lvl, ext_d;

  // internal divider: square wave, period 2*INT_HALF
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      int_lvl <= 1'b0;
    end else if (div_q == DIV_W'(INT_HALF - 1)) begin
      div_q   <= '0;
      int_lvl <= ~int_lvl;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // synchronizer chain for the external clock
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_clk_i;
      end
    end
  endgenerate

  assign ext_lvl = sync_q[SYNC_STAGES-1];

  // each source keeps its own delayed copy, so switching source makes no false edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_d <= 1'b0;
      ext_d <= 1'b0;
    end else begin
      int_d <= int_lvl;
      ext_d <= ext_lvl;
    end
  end

  always_comb begin
    if (src == SRC_EXT) begin
      lvl  = ext_lvl;
      rise = ext_lvl & ~ext_d;
      fall = ~ext_lvl & ext_d;
    end else begin
      lvl  = int_lvl;
      rise = int_lvl & ~int_d;
      fall = ~int_lvl & int_d;
    end
  end
endmodule

// File: rtl/cnvclk_seq.sv
module cnvclk_seq
  import cnvclk_pkg::*;
#(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ext_sel_i,
  input  logic cs_n_i,
  input  logic rd_n_i,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  output src_e src,
  output logic busy,
  output logic eoc,
  output logic eng_clk,
  output logic clk_out
);
  localparam int CNT_W = cnt_width(CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic open_q, nxt_open, accept, last;

  always_comb begin
    accept   = start_i & ~cs_n_i & ~busy;
    last     = open_q & fall & (cnt_q == CNT_W'(CYCLES - 1));
    nxt_open = open_q;
    if (busy & ~open_q & rise) nxt_open = 1'b1;
    if (last)                  nxt_open = 1'b0;
    if (accept)                nxt_open = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      eoc     <= 1'b0;
      open_q  <= 1'b0;
      cnt_q   <= '0;
      src     <= SRC_INT;
      eng_clk <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      open_q  <= nxt_open;
      eng_clk <= nxt_open & lvl;
      clk_out <= nxt_open & lvl & ~cs_n_i & ~rd_n_i;
      if (accept) begin
        busy  <= 1'b1;
        eoc   <= 1'b0;
        cnt_q <= '0;
        src   <= ext_sel_i ? SRC_EXT : SRC_INT;
      end else if (open_q & fall) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          eoc  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cnvclk_gate_ctrl.sv
module cnvclk_gate_ctrl
  import cnvclk_pkg::*;
#(
  parameter int CYCLES      = 16,
  parameter int INT_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ext_sel_i,
  input  logic ext_clk_i,
  input  logic cs_n_i,
  input  logic rd_n_i,
  output logic eng_clk_o,
  output logic busy_o,
  output logic eoc_o,
  output logic clk_out_o
);
  src_e src;
  logic lvl, rise, fall;

  cnvclk_src #(.INT_HALF(INT_HALF), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .src(src), .ext_clk_i(ext_clk_i),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  cnvclk_seq #(.CYCLES(CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_sel_i(ext_sel_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .lvl(lvl), .rise(rise), .fall(fall),
    .src(src), .busy(busy_o), .eoc(eoc_o), .eng_clk(eng_clk_o),
    .clk_out(clk_out_o)
  );
endmodule

// File: rtl/cnvclk_gate_chk.sv
module cnvclk_gate_chk #(
  parameter int CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cs_n_i,
  input logic rd_n_i,
  input logic eng_clk_o,
  input logic busy_o,
  input logic eoc_o,
  input logic clk_out_o
);
  localparam int NW = $clog2(CYCLES) + 2;
  logic [NW-1:0] n_q;
  logic eng_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q      <= '0;
      eng_prev <= 1'b0;
    end else begin
      eng_prev <= eng_clk_o;
      if (!busy_o)                    n_q <= '0;
      else if (eng_clk_o & ~eng_prev) n_q <= n_q + 1'b1;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cs_n_i && !busy_o) |=> (busy_o && !eoc_o));
  p_no_idle_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clk_o |-> busy_o);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NW'(CYCLES));
  p_exact_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (n_q == NW'(CYCLES)));
  p_end_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($fell(eng_clk_o) && eoc_o));
  p_eoc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !eoc_o);
  p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_o |-> (eng_clk_o && $past(!cs_n_i && !rd_n_i)));
  p_mirror_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_clk_o && $past(!cs_n_i && !rd_n_i)) |-> clk_out_o);
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cs_n_i && !busy_o) |=> !busy_o);
endmodule

bind cnvclk_gate_ctrl cnvclk_gate_chk #(.CYCLES(CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_n_i(cs_n_i),
  .rd_n_i(rd_n_i), .eng_clk_o(eng_clk_o), .busy_o(busy_o),
  .eoc_o(eoc_o), .clk_out_o(clk_out_o)
);

// File: tb/sim_cnvclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_cnvclk_gate_ctrl;
  localparam int CYCLES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, ext_sel_i = 1'b0, ext_clk_i = 1'b0;
  logic cs_n_i = 1'b0, rd_n_i = 1'b0, ext_run = 1'b0;
  logic eng_clk_o, busy_o, eoc_o, clk_out_o;

  int checks = 0, fails = 0, cyc = 0;
  int exp_eng_q[$];
  int exp_out_q[$];
  int eng_cnt = 0, out_cnt = 0, idle_rises = 0;
  logic p_busy = 1'b0, p_eng = 1'b0, p_out = 1'b0;

  always #2 clk = ~clk;          // 250 MHz
  always #20 if (ext_run) ext_clk_i = ~ext_clk_i;

  cnvclk_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_sel_i(ext_sel_i),
    .ext_clk_i(ext_clk_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .eng_clk_o(eng_clk_o), .busy_o(busy_o), .eoc_o(eoc_o),
    .clk_out_o(clk_out_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // monitor: count pulses per conversion, compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (eng_clk_o && !p_eng) begin
        if (busy_o) eng_cnt++;
        else idle_rises++;
      end
      if (clk_out_o && !p_out) out_cnt++;
      if (p_busy && !busy_o) begin
        chk(eoc_o && p_eng && !eng_clk_o, "R4 end edge", int'(eoc_o), 1);
        if (exp_eng_q.size() == 0) begin
          chk(1'b0, "R8 unexpected conversion", 1, 0);
        end else begin
          automatic int ee = exp_eng_q.pop_front();
          automatic int eo = exp_out_q.pop_front();
          chk(eng_cnt == ee, "R3 engine pulses", eng_cnt, ee);
          chk(out_cnt == eo, "R6 clock-out pulses", out_cnt, eo);
        end
      end
      if (!busy_o && !p_busy) begin
        eng_cnt = 0;
        out_cnt = 0;
      end
    end
    p_busy = busy_o;
    p_eng  = eng_clk_o;
    p_out  = clk_out_o;
  end

  task automatic run_conv(input bit ext, input bit rd, input bit flip,
                          input bit restart, input int exp_out, output int dur);
    exp_eng_q.push_back(CYCLES);
    exp_out_q.push_back(exp_out);
    @(negedge clk);
    ext_sel_i = ext; rd_n_i = rd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !eoc_o, "R2 accept", int'(busy_o), 1);
    dur = 1;
    while (busy_o && dur < 2000) begin
      @(negedge clk);
      dur++;
      if (dur == 30 && flip) ext_sel_i = ~ext_sel_i;
      if (dur == 40 && restart) start_i = 1'b1;
      if (dur == 41) start_i = 1'b0;
    end
    repeat (60) @(negedge clk);
    chk(!busy_o && eoc_o, "R4 eoc held", int'(eoc_o), 1);
    chk(exp_eng_q.size() == 0, "R8 queue drained", exp_eng_q.size(), 0);
  endtask

  initial begin
    int d;
    repeat (5) @(negedge clk);
    chk(!busy_o && !eoc_o && !eng_clk_o && !clk_out_o, "R1 in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy_o && !eoc_o && !eng_clk_o && !clk_out_o, "R1 after reset", int'(busy_o), 0);

    // internal source, both selects low
    run_conv(1'b0, 1'b0, 1'b0, 1'b0, CYCLES, d);
    chk(d <= 140, "R5 internal duration", d, 140);

    // external source, running continuously
    ext_run = 1'b1;
    repeat (10) @(negedge clk);
    run_conv(1'b1, 1'b0, 1'b0, 1'b0, CYCLES, d);
    chk(d >= 150, "R5 external duration", d, 150);
    repeat (100) @(negedge clk);
    chk(idle_rises == 0, "R3 no pulses after cutoff", idle_rises, 0);

    // read high: clock-out stays low
    run_conv(1'b0, 1'b1, 1'b0, 1'b0, 0, d);

    // chip-select high: start ignored
    @(negedge clk);
    cs_n_i = 1'b1; rd_n_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R7 start inhibited", int'(busy_o), 0);
    repeat (100) @(negedge clk);
    chk(!busy_o && idle_rises == 0, "R7 no conversion", idle_rises, 0);
    cs_n_i = 1'b0;

    // second start during a conversion
    run_conv(1'b0, 1'b0, 1'b0, 1'b1, CYCLES, d);

    // select flipped during an external conversion
    run_conv(1'b1, 1'b0, 1'b1, 1'b0, CYCLES, d);
    chk(d >= 150, "R5 select latched", d, 150);

    chk(idle_rises == 0, "R3 idle pulses total", idle_rises, 0);
    finish_run();
  end
endmodule